// File: doc/BRIEF.md
# Descriptor-Table DMA Channel Sequencer

This block sequences one DMA channel through a ring of eight buffer descriptors held in a small local descriptor store. Software loads descriptors through a host word port. It then writes START or STOP codes into a command input. On START the sequencer reads the descriptor at its current index. It drives a single-beat memory-to-memory mover through a read-request / read-response / write-request stream interface. When the descriptor is finished, the sequencer writes its control word back with the ready bit cleared and steps the index forward.

The channel pauses for four reasons: no ready descriptor, an external done input (when the done-mode input is 0), a STOP command, or completion of a descriptor marked last. Three of these raise sticky status events, and each event can drive the interrupt output if its mask bit is set. STOP has no event. The index survives pauses, so a later START carries on with the next unprocessed descriptor.

Every request toward memory follows valid/ready rules. Once a request's valid is high, it stays high with address and data unchanged until its ready is seen high at a clock edge. Only one beat is outstanding at a time. Read responses carry no ready signal: the mover takes `rd_resp_valid` whenever it arrives after an accepted read request.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset, `evt_status` is 0, `irq` is low, `busy` is low and `cur_idx` is 0.
- R2: A START (`cmd_valid` with `cmd_op` = 2'b01) while paused processes descriptors from `cur_idx` onward. The descriptor layout is as follows. The host word address is index*4 + word. Word 0 is control: bit 0 is ready and bit 1 is last. Word 1 is the byte count. Word 2 is the source and word 3 is the destination. Each descriptor copies ceil(count/4) 32-bit beats, and both addresses step by 4 per beat.
- R3: When a descriptor closes, its word 0 is written back with bit 0 cleared and the other bits kept, and `cur_idx` advances by one, wrapping from 7 to 0.
- R4: After closing a descriptor whose last bit is set, the channel pauses and sets event bit 2.
- R5: If the descriptor at `cur_idx` has its ready bit clear, the channel pauses, sets event bit 0, and leaves both `cur_idx` and the descriptor unchanged.
- R6: `ext_done` high while `dt_mode` is 0 during processing has this effect: the beat in flight completes, no new beat starts, the descriptor is closed as in R3, the channel pauses, and event bit 1 is set. While `dt_mode` is 1, `ext_done` has no effect.
- R7: A STOP (`cmd_op` = 2'b10) during processing behaves like R6 but sets no event. A STOP while paused has no effect. If STOP and a qualifying `ext_done` arrive together, event bit 1 is set.
- R8: A START that arrives while `busy` is high is ignored.
- R9: A descriptor with a zero byte count moves no beats, raises no event, and is closed normally.
- R10: Event bits are sticky and are cleared by writing 1 to `evt_clr`. If an event is set in the same cycle that it is cleared, the set wins.
- R11: `irq` is high exactly when some event bit and its `evt_mask` bit are both 1.
- R12: `rd_req_valid` and `wr_valid` hold, with their address and data stable, until the matching ready is seen. A read and a write request are never both outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 = START, 10 = STOP |
| dt_mode | input | 1 | 0: external done pauses the channel; 1: it is ignored |
| ext_done | input | 1 | External done request |
| evt_mask | input | 3 | Interrupt enable per event bit |
| evt_clr | input | 3 | Write-1-to-clear strobes for the event bits |
| evt_status | output | 3 | Events: bit 0 out of descriptors, bit 1 external done, bit 2 last done |
| irq | output | 1 | Masked OR of the events |
| busy | output | 1 | Channel is processing |
| cur_idx | output | 3 | Current descriptor index |
| hw_en | input | 1 | Host descriptor write strobe |
| hw_addr | input | 5 | Host write word address |
| hw_data | input | 32 | Host write data |
| hr_addr | input | 5 | Host read word address |
| hr_data | output | 32 | Host read data (combinational) |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request ready |
| rd_req_addr | output | 32 | Read byte address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request ready |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |

## Verification
Two pairs of functions can fall in one cycle. In the first pair, a STOP command and a qualifying external done are driven in the same cycle in the middle of a long descriptor. The bench expects a single pause, event bit 1 set, and the index advanced by exactly one. In the second pair, an out-of-descriptors event is provoked while its write-1-to-clear strobe is held across the command cycle and the following cycle. The strobe clears the old bit first and then meets the new set, so the bit must read 1 afterwards. A design in which clear wins would read 0.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int WORD_W = 32;
  localparam int EV_OB   = 0;
  localparam int EV_EXT  = 1;
  localparam int EV_LAST = 2;
  localparam int EV_N    = 3;

  localparam logic [1:0] OP_START = 2'b01;
  localparam logic [1:0] OP_STOP  = 2'b10;

  localparam int CTL_RDY  = 0;
  localparam int CTL_LAST = 1;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_MOVE, S_WB} seq_st_t;
  typedef enum logic [1:0] {E_IDLE, E_RA, E_RD, E_WR} eng_st_t;

  typedef struct packed {
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] cnt;
    logic [WORD_W-1:0] ctl;
  } desc_t;
endpackage

// File: rtl/desc_ram.sv
module desc_ram
  import dma_seq_pkg::*;
#(
  parameter int N_DESC = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hw_en,
  input  logic [$clog2(N_DESC)+1:0] hw_addr,
  input  logic [WORD_W-1:0]     hw_data,
  input  logic [$clog2(N_DESC)+1:0] hr_addr,
  output logic [WORD_W-1:0]     hr_data,
  input  logic [$clog2(N_DESC)-1:0] sq_idx,
  output desc_t                 sq_row,
  input  logic                  sq_we,
  input  logic [WORD_W-1:0]     sq_ctl
);
  localparam int IW     = $clog2(N_DESC);
  localparam int NWORDS = N_DESC * 4;

  logic [WORD_W-1:0] mem [NWORDS];
  logic [WORD_W-1:0] row_w [4];

  // Sequencer write-back is placed last so it takes priority on a collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else begin
      if (hw_en) mem[hw_addr] <= hw_data;
      if (sq_we) mem[{sq_idx, 2'b00}] <= sq_ctl;
    end
  end

  for (genvar w = 0; w < 4; w++) begin : g_row
    assign row_w[w] = mem[{sq_idx, 2'(w)}];
  end

  assign sq_row  = '{dst: row_w[3], src: row_w[2], cnt: row_w[1], ctl: row_w[0]};
  assign hr_data = mem[hr_addr];

  logic unused_iw;
  assign unused_iw = (IW == 0);
endmodule

// File: rtl/beat_mover.sv
module beat_mover
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [CW-1:0] nbytes,
  input  logic          abort,
  output logic          done,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_resp_valid,
  input  logic [DW-1:0] rd_resp_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int BW = CW - 1;

  eng_st_t        st;
  logic [BW-1:0]  left;
  logic [BW-1:0]  go_beats;
  logic [AW-1:0]  sa, da;
  logic [DW-1:0]  buf_q;
  logic           done_q;

  // Byte count rounded up to whole 32-bit beats.
  assign go_beats = BW'(nbytes[CW-1:2]) + BW'(|nbytes[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      left   <= '0;
      sa     <= '0;
      da     <= '0;
      buf_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        E_IDLE: if (go) begin
          sa   <= src;
          da   <= dst;
          left <= go_beats;
          if (go_beats == '0) done_q <= 1'b1;
          else                st     <= E_RA;
        end
        E_RA: if (rd_req_ready) st <= E_RD;
        E_RD: if (rd_resp_valid) begin
          buf_q <= rd_resp_data;
          st    <= E_WR;
        end
        E_WR: if (wr_ready) begin
          sa   <= sa + AW'(4);
          da   <= da + AW'(4);
          left <= left - BW'(1);
          if (left == BW'(1) || abort) begin
            done_q <= 1'b1;
            st     <= E_IDLE;
          end else begin
            st <= E_RA;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (st == E_RA);
  assign rd_req_addr  = sa;
  assign wr_valid     = (st == E_WR);
  assign wr_addr      = da;
  assign wr_data      = buf_q;
  assign done         = done_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R12
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R12
  AST_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid)); // R12
endmodule

// File: rtl/chan_events.sv
module chan_events #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] status,
  output logic         irq
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status[b] <= 1'b0;
      else if (set[b]) status[b] <= 1'b1;
      else if (clr[b]) status[b] <= 1'b0;
    end
  end

  assign irq = |(status & mask);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((status & $past(set)) == $past(set))); // R10
  AST_CLR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set) != '0) |=> ((status & $past(clr & ~set)) == '0)); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R11
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
  import dma_seq_pkg::*;
#(
  parameter int N_DESC = 8,
  parameter int AW     = 32,
  parameter int DW     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic                      dt_mode,
  input  logic                      ext_done,
  input  logic [2:0]                evt_mask,
  input  logic [2:0]                evt_clr,
  output logic [2:0]                evt_status,
  output logic                      irq,
  output logic                      busy,
  output logic [$clog2(N_DESC)-1:0] cur_idx,
  input  logic                      hw_en,
  input  logic [$clog2(N_DESC)+1:0] hw_addr,
  input  logic [31:0]               hw_data,
  input  logic [$clog2(N_DESC)+1:0] hr_addr,
  output logic [31:0]               hr_data,
  output logic                      rd_req_valid,
  input  logic                      rd_req_ready,
  output logic [AW-1:0]             rd_req_addr,
  input  logic                      rd_resp_valid,
  input  logic [DW-1:0]             rd_resp_data,
  output logic                      wr_valid,
  input  logic                      wr_ready,
  output logic [AW-1:0]             wr_addr,
  output logic [DW-1:0]             wr_data
);
  localparam int IW = $clog2(N_DESC);

  seq_st_t        st, st_n;
  logic [IW-1:0]  idx;
  logic           ext_pend, stop_pend, clr_pend;
  logic           cmd_start, cmd_stop, ext_hit, ext_now, stop_now;
  logic           go, eng_done, eng_abort, sq_we;
  logic [EV_N-1:0] ev_set;
  desc_t          row;
  logic [WORD_W-1:0] wb_ctl;

  assign cmd_start = cmd_valid && (cmd_op == OP_START);
  assign cmd_stop  = cmd_valid && (cmd_op == OP_STOP);
  assign ext_hit   = ext_done && !dt_mode;
  assign ext_now   = ext_pend | ext_hit;
  assign stop_now  = stop_pend | cmd_stop;
  assign eng_abort = ext_now | stop_now;
  assign wb_ctl    = {row.ctl[WORD_W-1:1], 1'b0};

  always_comb begin
    st_n     = st;
    go       = 1'b0;
    sq_we    = 1'b0;
    clr_pend = 1'b0;
    ev_set   = '0;
    case (st)
      S_IDLE: begin
        clr_pend = 1'b1;
        if (cmd_start) st_n = S_CHECK;
      end
      S_CHECK: begin
        if (ext_hit) begin
          ev_set[EV_EXT] = 1'b1;
          st_n = S_IDLE;
        end else if (cmd_stop) begin
          st_n = S_IDLE;
        end else if (!row.ctl[CTL_RDY]) begin
          ev_set[EV_OB] = 1'b1;
          st_n = S_IDLE;
        end else begin
          go       = 1'b1;
          clr_pend = 1'b1;
          st_n     = S_MOVE;
        end
      end
      S_MOVE: if (eng_done) st_n = S_WB;
      S_WB: begin
        sq_we = 1'b1;
        if (ext_now) begin
          ev_set[EV_EXT] = 1'b1;
          st_n = S_IDLE;
        end else if (stop_now) begin
          st_n = S_IDLE;
        end else if (row.ctl[CTL_LAST]) begin
          ev_set[EV_LAST] = 1'b1;
          st_n = S_IDLE;
        end else begin
          st_n = S_CHECK;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      ext_pend  <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      st <= st_n;
      if (st == S_WB) idx <= idx + IW'(1);
      if (clr_pend) begin
        ext_pend  <= 1'b0;
        stop_pend <= 1'b0;
      end else begin
        ext_pend  <= ext_now;
        stop_pend <= stop_now;
      end
    end
  end

  desc_ram #(.N_DESC(N_DESC)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_en   (hw_en),
    .hw_addr (hw_addr),
    .hw_data (hw_data),
    .hr_addr (hr_addr),
    .hr_data (hr_data),
    .sq_idx  (idx),
    .sq_row  (row),
    .sq_we   (sq_we),
    .sq_ctl  (wb_ctl)
  );

  beat_mover #(.AW(AW), .DW(DW), .CW(WORD_W)) u_mover (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (go),
    .src           (AW'(row.src)),
    .dst           (AW'(row.dst)),
    .nbytes        (row.cnt),
    .abort         (eng_abort),
    .done          (eng_done),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_req_addr   (rd_req_addr),
    .rd_resp_valid (rd_resp_valid),
    .rd_resp_data  (rd_resp_data),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data)
  );

  chan_events #(.N(EV_N)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (ev_set),
    .clr    (evt_clr),
    .mask   (evt_mask),
    .status (evt_status),
    .irq    (irq)
  );

  assign busy    = (st != S_IDLE);
  assign cur_idx = idx;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB) |=> (cur_idx == IW'($past(cur_idx) + IW'(1)))); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_WB) |=> $stable(cur_idx)); // R5
  AST_OB_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_status[EV_OB]) |-> !busy); // R5
  AST_EXT_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB && ext_pend) |=> (st == S_IDLE)); // R6
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MOVE && cmd_start && !eng_done) |=> busy); // R8
endmodule

// File: tb/dma_desc_seq_bench.sv
module dma_desc_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 3;
  localparam logic [31:0] SENT = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic dt_mode = 1'b0, ext_done = 1'b0;
  logic [2:0] evt_mask = 3'b111, evt_clr = 3'b000;
  logic [2:0] evt_status;
  logic irq, busy;
  logic [IW-1:0] cur_idx;
  logic hw_en = 1'b0;
  logic [IW+1:0] hw_addr = '0, hr_addr = '0;
  logic [31:0] hw_data = '0, hr_data;
  logic rd_req_valid, rd_req_ready, rd_resp_valid;
  logic [31:0] rd_req_addr, rd_resp_data;
  logic wr_valid, wr_ready;
  logic [31:0] wr_addr, wr_data;

  int checks = 0, fails = 0;
  logic [7:0] cyc;
  logic [31:0] dmem [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_seq u_dma_desc_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .dt_mode(dt_mode), .ext_done(ext_done), .evt_mask(evt_mask), .evt_clr(evt_clr),
    .evt_status(evt_status), .irq(irq), .busy(busy), .cur_idx(cur_idx),
    .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data), .hr_addr(hr_addr),
    .hr_data(hr_data), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [31:0] srcf(logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  // Memory model with irregular back-pressure on both request channels.
  assign rd_req_ready = cyc[0] | cyc[2];
  assign wr_ready     = ~cyc[1] | cyc[3];
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0;
      rd_resp_valid <= 1'b0;
      rd_resp_data <= '0;
      for (int i = 0; i < 1024; i++) dmem[i] <= SENT;
    end else begin
      cyc <= cyc + 8'd1;
      rd_resp_valid <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
        rd_resp_valid <= 1'b1;
        rd_resp_data <= srcf(rd_req_addr);
      end
      if (wr_valid && wr_ready) dmem[wr_addr[11:2]] <= wr_data;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input int addr, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = (IW+2)'(addr); hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic set_desc(input int i, input logic [31:0] ctl, input logic [31:0] cnt,
                          input logic [31:0] s, input logic [31:0] d);
    hwrite(i*4, ctl); hwrite(i*4+1, cnt); hwrite(i*4+2, s); hwrite(i*4+3, d);
  endtask

  task automatic hread(input int addr, output logic [31:0] v);
    hr_addr = (IW+2)'(addr);
    #1 v = hr_data;
  endtask

  task automatic issue(input logic [1:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (!busy) return;
    end
    check("idle-timeout", 32'd1, 32'd0);
  endtask

  task automatic clear_all();
    @(negedge clk); evt_clr = 3'b111;
    @(negedge clk); evt_clr = 3'b000;
  endtask

  task automatic check_copy(input string req, input logic [31:0] s, input logic [31:0] d,
                            input int beats);
    for (int k = 0; k < beats; k++)
      check(req, dmem[(d + 32'(4*k)) >> 2], srcf(s + 32'(4*k)));
    check(req, dmem[(d + 32'(4*beats)) >> 2], SENT);
  endtask

  // Counts the correct prefix of a partial copy and checks the rest is untouched.
  task automatic check_partial(input string req, input logic [31:0] s, input logic [31:0] d,
                               input int maxb);
    int k = 0;
    while (k < maxb && dmem[(d + 32'(4*k)) >> 2] == srcf(s + 32'(4*k))) k++;
    for (int j = k; j < maxb; j++) check(req, dmem[(d + 32'(4*j)) >> 2], SENT);
    check(req, 32'((k > 0) && (k < maxb)), 32'd1);
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", 32'(evt_status), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 idx", 32'(cur_idx), 32'd0);

    // R2 R3 R4: three descriptors, odd byte count rounds up
    set_desc(0, 32'h1, 32'd8,  32'h100, 32'h800);
    set_desc(1, 32'h1, 32'd10, 32'h200, 32'h880);
    set_desc(2, 32'h3, 32'd4,  32'h300, 32'h900);
    issue(2'b01);
    wait_idle();
    check_copy("R2 d0", 32'h100, 32'h800, 2);
    check_copy("R2 d1", 32'h200, 32'h880, 3);
    check_copy("R2 d2", 32'h300, 32'h900, 1);
    check("R4 status", 32'(evt_status), 32'h4);
    check("R11 irq", 32'(irq), 32'd1);
    check("R3 idx", 32'(cur_idx), 32'd3);
    hread(0, v); check("R3 ctl0", v, 32'h0);
    hread(4, v); check("R3 ctl1", v, 32'h0);
    hread(8, v); check("R3 ctl2", v, 32'h2);

    // R10 write-1-to-clear
    clear_all();
    check("R10 cleared", 32'(evt_status), 32'd0);
    check("R11 irq low", 32'(irq), 32'd0);

    // R7 STOP while paused
    issue(2'b10);
    @(negedge clk);
    check("R7 idle stop busy", 32'(busy), 32'd0);
    check("R7 idle stop idx", 32'(cur_idx), 32'd3);
    check("R7 idle stop status", 32'(evt_status), 32'd0);

    // R5 out of descriptors
    issue(2'b01);
    wait_idle();
    check("R5 status", 32'(evt_status), 32'h1);
    check("R5 idx", 32'(cur_idx), 32'd3);
    hread(12, v); check("R5 ctl", v, 32'h0);
    evt_mask = 3'b110;
    #1 check("R11 masked", 32'(irq), 32'd0);
    evt_mask = 3'b111;
    #1 check("R11 unmasked", 32'(irq), 32'd1);
    clear_all();

    // R9 zero length then R6 external done; R8 START while busy
    set_desc(3, 32'h1, 32'd0,  32'h380, 32'h980);
    set_desc(4, 32'h1, 32'd40, 32'h400, 32'hA00);
    set_desc(5, 32'h1, 32'd40, 32'h500, 32'hB00);
    issue(2'b01);
    repeat (6) @(negedge clk);
    issue(2'b01);
    repeat (4) @(negedge clk);
    dt_mode = 1'b1; ext_done = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 dt1 ignored", 32'(busy), 32'd1);
    ext_done = 1'b0; dt_mode = 1'b0;
    @(negedge clk);
    ext_done = 1'b1;
    wait_idle();
    ext_done = 1'b0;
    check("R6 status", 32'(evt_status), 32'h2);
    check("R6 idx", 32'(cur_idx), 32'd5);
    hread(12, v); check("R9 ctl3", v, 32'h0);
    check("R9 no write", dmem[32'h980 >> 2], SENT);
    hread(16, v); check("R6 ctl4", v, 32'h0);
    hread(20, v); check("R6 ctl5", v, 32'h1);
    check_partial("R6 partial", 32'h400, 32'hA00, 10);
    clear_all();

    // R7 STOP mid-descriptor
    issue(2'b01);
    repeat (10) @(negedge clk);
    issue(2'b10);
    wait_idle();
    check("R7 status", 32'(evt_status), 32'h0);
    check("R7 idx", 32'(cur_idx), 32'd6);
    hread(20, v); check("R7 ctl5", v, 32'h0);
    check_partial("R7 partial", 32'h500, 32'hB00, 10);

    // R3 wrap 7 -> 0
    set_desc(6, 32'h1, 32'd4,  32'h600, 32'hC00);
    set_desc(7, 32'h1, 32'd8,  32'h700, 32'hC80);
    set_desc(0, 32'h3, 32'd12, 32'h780, 32'hD00);
    issue(2'b01);
    wait_idle();
    check("R3 wrap idx", 32'(cur_idx), 32'd1);
    check("R4 wrap status", 32'(evt_status), 32'h4);
    check_copy("R2 d6", 32'h600, 32'hC00, 1);
    check_copy("R2 d7", 32'h700, 32'hC80, 2);
    check_copy("R2 d0w", 32'h780, 32'hD00, 3);
    clear_all();

    // R7 R6 STOP and external done in the same cycle
    set_desc(1, 32'h1, 32'd40, 32'h880, 32'hE00);
    issue(2'b01);
    repeat (10) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; ext_done = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00; ext_done = 1'b0;
    wait_idle();
    check("R7 both status", 32'(evt_status), 32'h2);
    check("R7 both idx", 32'(cur_idx), 32'd2);
    clear_all();

    // R10 set wins over clear in the same cycle
    issue(2'b01);
    wait_idle();
    check("R5 ob again", 32'(evt_status), 32'h1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; evt_clr = 3'b001;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    @(negedge clk);
    evt_clr = 3'b000;
    @(negedge clk);
    check("R10 set wins", 32'(evt_status), 32'h1);
    check("R5 idx hold", 32'(cur_idx), 32'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule